// File: doc/BRIEF.md
# Inter-Processor and Interval-Timer Interrupt Controller

This block keeps, for up to four CPUs, one pending bit for an inter-processor interrupt (IPI) and one pending bit for the interval-timer interrupt. Software changes that state through single 64-bit control writes. Each write carries three independent per-CPU masks: one requests IPIs, one clears IPIs and one clears timer interrupts. A one-cycle timer tick input posts the timer interrupt to every present CPU at once. The block only holds and delivers the interrupt; generating the timer period is left to other logic.

A read is combinational. It returns both pending vectors together with the 2-bit number of the CPU making the access, so each CPU can find its own index from the same word. The IPI pending vector and the timer pending vector each drive their own per-CPU interrupt level, separate from any device interrupt level. The block also raises one-cycle strobes when a request targets a CPU whose IPI is already pending, when a clear targets a CPU with nothing pending, and when a write selects no CPU at all.

The parameter `NUM_CPU` (1 to 4) sets how many CPUs are present. Mask bits for CPU indices at or above `NUM_CPU` have no effect.

Top module: `xcpu_irq_hub`

## Requirements
- R1: A write with bit 12+i set (i = CPU index, i < NUM_CPU) sets the IPI pending bit of CPU i when the write takes effect at the clock edge.
- R2: A request (bit 12+i) for CPU i whose IPI is still pending after this write's clears leaves its state unchanged, and `warnDupReq` is high for the one cycle after that edge.
- R3: A write with bit 8+i set clears CPU i's IPI pending bit. If that bit was not pending, `warnIdleClr` is high for the one cycle after the edge.
- R4: A write with bit 4+i set clears CPU i's timer pending bit, unless a tick arrives in the same cycle.
- R5: A tick sets the timer pending bit of every present CPU at the clock edge. A tick wins over a timer clear in the same cycle.
- R6: When one write both clears (bit 8+i) and requests (bit 12+i) an IPI for the same CPU, the clear is applied first. The IPI ends up pending and `warnDupReq` stays low.
- R7: `rdData` holds the IPI pending vector in bits [11:8], the timer pending vector in bits [7:4] and `accCpu` in bits [1:0]. All other bits are zero. It follows its inputs with no clock delay.
- R8: Mask bits for CPUs at index NUM_CPU or above are ignored. Their `ipiIrq`/`tmrIrq` bits and read bits stay zero.
- R9: A write whose request, IPI-clear and timer-clear masks are all zero after masking out absent CPUs raises `errNoSel` for the one cycle after the edge and changes no pending state.
- R10: Reset clears both pending vectors and all strobes. `ipiIrq` and `tmrIrq` mirror the pending vectors in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control write strobe |
| wrData | input | 64 | Write word: request [15:12], IPI clear [11:8], timer clear [7:4] |
| tick | input | 1 | Timer tick, posts timer interrupt to all present CPUs |
| accCpu | input | 2 | Number of the CPU performing the access |
| rdData | output | 64 | Read word: IPI pending, timer pending, accessing CPU |
| ipiIrq | output | 4 | Per-CPU IPI interrupt level |
| tmrIrq | output | 4 | Per-CPU timer interrupt level |
| warnDupReq | output | 1 | Pulse: request hit an already pending IPI |
| warnIdleClr | output | 1 | Pulse: IPI clear hit a CPU with nothing pending |
| errNoSel | output | 1 | Pulse: write selected no present CPU |

## Verification
Assertions check on every cycle that requested CPUs end up pending, that cleared CPUs end up idle, that a tick leaves every present CPU with a timer pending, that a redundant request raises its strobe, that a write selecting no CPU leaves state untouched, and that absent CPUs stay quiet. Only the bench scenarios can show the exact values of the strobes across whole sequences. The same goes for the ordering when a clear and a request for one CPU share a word, a tick colliding with a timer clear, and the read word's layout for each accessing CPU. The bench compares against a reference model under mixed random and directed writes.

// File: rtl/xcpu_irq_pkg.sv
`timescale 1ns/1ps
package xcpu_irq_pkg;
  localparam int MAX_CPU  = 4;
  localparam int CPU_ID_W = $clog2(MAX_CPU);
  // field positions inside the control word (software decodes these)
  localparam int REQ_LSB  = 12;
  localparam int CLR_LSB  = 8;
  localparam int TCLR_LSB = 4;
  // field positions inside the read word
  localparam int RD_IPI_LSB = 8;
  localparam int RD_TMR_LSB = 4;

  typedef logic [MAX_CPU-1:0] cpuVec_t;

  // strobes from control to datapath, one bit per CPU
  typedef struct packed {
    cpuVec_t ipiSet;
    cpuVec_t ipiClr;
    cpuVec_t tmrSet;
    cpuVec_t tmrClr;
  } pendUpd_t;

  function automatic cpuVec_t presentMask(input int n);
    cpuVec_t m;
    for (int i = 0; i < MAX_CPU; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/xcpu_irq_ctrl.sv
`timescale 1ns/1ps
module xcpu_irq_ctrl
  import xcpu_irq_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  input  cpuVec_t           ipiPend,
  input  cpuVec_t           tmrPend,
  output pendUpd_t          upd,
  output logic              warnDupReq,
  output logic              warnIdleClr,
  output logic              errNoSel
);
  localparam cpuVec_t PRESENT = presentMask(NUM_CPU);

  cpuVec_t reqMask, clrMask, tclrMask, heldAfterClr;
  logic    noSel;
  logic    wrUnused;

  assign wrUnused = ^{wrData[DATA_W-1:REQ_LSB+MAX_CPU], wrData[TCLR_LSB-1:0]};

  always_comb begin
    reqMask  = '0;
    clrMask  = '0;
    tclrMask = '0;
    if (wrEn) begin
      reqMask  = wrData[REQ_LSB  +: MAX_CPU] & PRESENT;
      clrMask  = wrData[CLR_LSB  +: MAX_CPU] & PRESENT;
      tclrMask = wrData[TCLR_LSB +: MAX_CPU] & PRESENT;
    end
  end

  assign noSel = (reqMask == '0) && (clrMask == '0) && (tclrMask == '0);

  // per-CPU update rules: clears act first, then requests and ticks
  for (genvar c = 0; c < MAX_CPU; c++) begin : g_cpu
    assign heldAfterClr[c] = ipiPend[c] & ~clrMask[c];
    assign upd.ipiClr[c]   = clrMask[c] & ipiPend[c];
    assign upd.ipiSet[c]   = reqMask[c] & ~heldAfterClr[c];
    assign upd.tmrClr[c]   = tclrMask[c] & tmrPend[c];
    assign upd.tmrSet[c]   = tick & PRESENT[c] & (~tmrPend[c] | tclrMask[c]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warnDupReq  <= 1'b0;
      warnIdleClr <= 1'b0;
      errNoSel    <= 1'b0;
    end else begin
      warnDupReq  <= |(reqMask & heldAfterClr);
      warnIdleClr <= |(clrMask & ~ipiPend);
      errNoSel    <= wrEn & noSel;
    end
  end

  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (reqMask != '0) |=> ((ipiPend & $past(reqMask)) == $past(reqMask))); // R1
  AST_DUP_WARN: assert property (@(posedge clk) disable iff (!rstN)
    ((reqMask & ipiPend & ~clrMask) != '0) |=> warnDupReq); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ((clrMask & ~reqMask) != '0) |=> ((ipiPend & $past(clrMask & ~reqMask)) == '0)); // R3
  AST_TCLR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ((tclrMask != '0) && !tick) |=> ((tmrPend & $past(tclrMask)) == '0)); // R4
  AST_TICK_ALL: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (tmrPend == PRESENT)); // R5
  AST_NOSEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && noSel && !tick) |=> ($stable(ipiPend) && $stable(tmrPend))); // R9
endmodule

// File: rtl/xcpu_irq_dp.sv
`timescale 1ns/1ps
module xcpu_irq_dp
  import xcpu_irq_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  pendUpd_t            upd,
  input  logic [CPU_ID_W-1:0] accCpu,
  output cpuVec_t             ipiPend,
  output cpuVec_t             tmrPend,
  output logic [DATA_W-1:0]   rdData
);
  localparam cpuVec_t PRESENT = presentMask(NUM_CPU);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ipiPend <= '0;
      tmrPend <= '0;
    end else begin
      ipiPend <= (ipiPend & ~upd.ipiClr) | upd.ipiSet;
      tmrPend <= (tmrPend & ~upd.tmrClr) | upd.tmrSet;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[RD_IPI_LSB +: MAX_CPU] = ipiPend;
    rdData[RD_TMR_LSB +: MAX_CPU] = tmrPend;
    rdData[CPU_ID_W-1:0]          = accCpu;
  end

  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((ipiPend & ~PRESENT) == '0) && ((tmrPend & ~PRESENT) == '0)); // R8
  AST_UPD_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    ((upd.ipiSet & ipiPend & ~upd.ipiClr) == '0)); // R2
endmodule

// File: rtl/xcpu_irq_hub.sv
`timescale 1ns/1ps
module xcpu_irq_hub
  import xcpu_irq_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                tick,
  input  logic [CPU_ID_W-1:0] accCpu,
  output logic [DATA_W-1:0]   rdData,
  output logic [MAX_CPU-1:0]  ipiIrq,
  output logic [MAX_CPU-1:0]  tmrIrq,
  output logic                warnDupReq,
  output logic                warnIdleClr,
  output logic                errNoSel
);
  pendUpd_t upd;
  cpuVec_t  ipiPend, tmrPend;

  xcpu_irq_ctrl #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .tick(tick),
    .ipiPend(ipiPend), .tmrPend(tmrPend), .upd(upd),
    .warnDupReq(warnDupReq), .warnIdleClr(warnIdleClr), .errNoSel(errNoSel)
  );

  xcpu_irq_dp #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .upd(upd), .accCpu(accCpu),
    .ipiPend(ipiPend), .tmrPend(tmrPend), .rdData(rdData)
  );

  assign ipiIrq = ipiPend;
  assign tmrIrq = tmrPend;
endmodule

// File: tb/tb_xcpu_irq_hub.sv
`timescale 1ns/1ps
module tb_xcpu_irq_hub;
  localparam int NCPU = 3;
  localparam logic [3:0] PM = 4'b0111;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic        tick = 1'b0;
  logic [1:0]  accCpu = '0;
  logic [63:0] rdData;
  logic [3:0]  ipiIrq, tmrIrq;
  logic        warnDupReq, warnIdleClr, errNoSel;

  int checks = 0;
  int errors = 0;
  logic [3:0] mIpi = '0, mTmr = '0;
  logic eDup = 1'b0, eClr = 1'b0, eErr = 1'b0;

  xcpu_irq_hub #(.NUM_CPU(NCPU), .DATA_W(64)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .tick(tick),
    .accCpu(accCpu), .rdData(rdData), .ipiIrq(ipiIrq), .tmrIrq(tmrIrq),
    .warnDupReq(warnDupReq), .warnIdleClr(warnIdleClr), .errNoSel(errNoSel)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rdExp(input logic [1:0] cpu);
    logic [63:0] r = '0;
    r[11:8] = mIpi;
    r[7:4]  = mTmr;
    r[1:0]  = cpu;
    return r;
  endfunction

  // reference model: clears, then requests; timer clear, then tick
  task automatic model(input bit wr, input logic [63:0] d, input bit tk);
    logic [3:0] req, clr, tclr;
    req  = wr ? (d[15:12] & PM) : 4'b0;
    clr  = wr ? (d[11:8]  & PM) : 4'b0;
    tclr = wr ? (d[7:4]   & PM) : 4'b0;
    eDup = 1'b0; eClr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (clr[i]) begin
        if (mIpi[i]) mIpi[i] = 1'b0; else eClr = 1'b1;
      end
      if (req[i]) begin
        if (mIpi[i]) eDup = 1'b1; else mIpi[i] = 1'b1;
      end
      if (tclr[i]) mTmr[i] = 1'b0;
      if (tk && PM[i]) mTmr[i] = 1'b1;
    end
    eErr = wr && (req == 0) && (clr == 0) && (tclr == 0);
  endtask

  task automatic step(input bit wr, input logic [63:0] d, input bit tk,
                      input logic [1:0] cpu, input string tag);
    @(negedge clk);
    wrEn = wr; wrData = d; tick = tk; accCpu = cpu;
    model(wr, d, tk);
    @(posedge clk);
    #1;
    wrEn = 1'b0; tick = 1'b0;
    chk({tag, " read word R7"}, rdData, rdExp(cpu));
    chk({tag, " ipi level R10"}, {60'b0, ipiIrq}, {60'b0, mIpi});
    chk({tag, " timer level R10"}, {60'b0, tmrIrq}, {60'b0, mTmr});
    chk({tag, " dup strobe R2"}, {63'b0, warnDupReq}, {63'b0, eDup});
    chk({tag, " idle clear strobe R3"}, {63'b0, warnIdleClr}, {63'b0, eClr});
    chk({tag, " no-select strobe R9"}, {63'b0, errNoSel}, {63'b0, eErr});
  endtask

  function automatic logic [63:0] word(input logic [3:0] rq, input logic [3:0] cl,
                                      input logic [3:0] tc);
    logic [63:0] w = '0;
    w[15:12] = rq; w[11:8] = cl; w[7:4] = tc;
    return w;
  endfunction

  bit done = 1'b0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    accCpu = 2'd2;
    repeat (3) @(posedge clk);
    #1;
    chk("reset ipi R10", {60'b0, ipiIrq}, 64'd0);
    chk("reset timer R10", {60'b0, tmrIrq}, 64'd0);
    chk("reset read R7", rdData, 64'd2);
    chk("reset strobes R10", {61'b0, warnDupReq, warnIdleClr, errNoSel}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    step(1, word(4'b0101, 0, 0), 0, 2'd0, "R1 request cpu0+cpu2");
    chk("R1 ipi after request", {60'b0, ipiIrq}, 64'h5);
    step(1, word(4'b0001, 0, 0), 0, 2'd1, "R2 repeat request");
    chk("R2 warn on repeat", {63'b0, warnDupReq}, 64'd1);
    step(1, word(0, 4'b0100, 0), 0, 2'd2, "R3 clear cpu2");
    chk("R3 ipi after clear", {60'b0, ipiIrq}, 64'h1);
    step(1, word(0, 4'b0010, 0), 0, 2'd0, "R3 clear idle cpu1");
    chk("R3 warn idle clear", {63'b0, warnIdleClr}, 64'd1);
    step(0, 64'd0, 1, 2'd1, "R5 tick");
    chk("R5 tick all present", {60'b0, tmrIrq}, 64'h7);
    step(1, word(0, 0, 4'b0010), 0, 2'd1, "R4 timer clear cpu1");
    chk("R4 timer after clear", {60'b0, tmrIrq}, 64'h5);
    step(1, word(0, 0, 4'b0001), 1, 2'd3, "R5 tick with timer clear");
    chk("R5 tick wins", {60'b0, tmrIrq}, 64'h7);
    step(1, word(4'b0001, 4'b0001, 0), 0, 2'd0, "R6 clear+request same cpu");
    chk("R6 ipi stays pending", {60'b0, ipiIrq}, 64'h1);
    chk("R6 no dup warn", {63'b0, warnDupReq}, 64'd0);
    step(1, word(4'b1000, 4'b1000, 4'b1000), 0, 2'd3, "R8 absent cpu only");
    chk("R8 absent ignored", {60'b0, ipiIrq}, 64'h1);
    chk("R9 absent-only is no select", {63'b0, errNoSel}, 64'd1);
    step(1, word(4'b1010, 0, 0), 0, 2'd3, "R8 mixed absent request");
    chk("R8 cpu3 level low", {63'b0, ipiIrq[3]}, 64'd0);
    chk("R7 read cpu3", rdData, 64'h0000_0000_0000_0373);
    step(1, 64'hFFFF_0000_0000_000F, 0, 2'd1, "R9 zero fields junk bits");
    chk("R9 state kept", {56'b0, ipiIrq, tmrIrq}, 64'h37);

    for (int n = 0; n < 600; n++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) d[15:4] = '0;
      if ($urandom_range(0, 1) == 0) d[15:12] = d[15:12] & 4'($urandom);
      step($urandom_range(0, 2) != 0, d, $urandom_range(0, 5) == 0,
           2'($urandom), "R1 random mix");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule